// File: doc/BRIEF.md
# Comparator-Network Uncompute Cleaner

This block returns a recorded sorting network to its starting state. A routing switch sorts a vector of destination tags through a fixed bitonic merge network. Each comparator in that network leaves one record bit: 1 if it exchanged its two tags, 0 if it did not. Before the workspace can be used for another routing round, the swaps must be undone and every record bit must go back to zero. The cleaner takes the sorted tag vector and the complete record vector, replays the network from the last layer back to the first, and delivers the original tag order, the cleared record vector and a flag that shows whether the clean-up left every record bit at zero.

Each inverse comparator works in two steps. It first swaps its two tags back if its record bit is set. It then re-compares the tags and clears the record bit if the lower-position tag is the larger one. This clears the bit exactly when a swap had been recorded. If a record bit has been corrupted, the re-compare can fail to clear it, and the flag then drops. One layer is processed per clock. A start pulse loads the inputs and a done pulse marks the end of the run. Payload data does not pass through the block; only the tags are restored.

Top module: `swrec_cleaner`

## Requirements
- R1: After reset, `done`, `clean`, `tags_out` and `recs_out` are all zero.
- R2: When the block is idle, a high `start` at a clock edge loads `tags_in` and `recs_in`. When the block is running, `start` is ignored and the run in progress finishes with the data it loaded.
- R3: After the loading edge, the block processes exactly one layer per edge, in reverse layer order. `done` is high for exactly one cycle, directly after the L-th edge that follows the loading edge, where L = LOG_N*(LOG_N+1)/2.
- R4: Each inverse element first swaps its lower and upper tag when its record bit is 1. It then clears that bit if the lower tag is now strictly greater than the upper tag. Otherwise the bit keeps its value, and the element never sets a bit.
- R5: Tag k occupies bits [k*TAG_W +: TAG_W]. Layers are numbered in forward order: stage s runs from 1 to LOG_N and step t from 0 to s-1. Comparator c of a layer uses a span z = 2^(s-t) and a half-span h = z/2. Its lower position is (c/h)*z + c%h. Its upper position is (c/h)*z + z-1-c%h when t = 0, and lower+h otherwise. Its record bit is at index layer*N/2 + c. Forward comparators swap when the lower tag is strictly greater.
- R6: When the inputs are the output tags and record bits of the forward network, the restored tags equal the forward network's original input and all record bits are zero.
- R7: With `done`, `clean` is 1 exactly when `recs_out` is all zero. `clean` holds that value until the next accepted start, which clears it.
- R8: When a record bit is set on a comparator whose two tags are equal, the bit is not cleared, so `clean` is 0 at `done`.
- R9: While the block is idle and `start` is low, `tags_out` and `recs_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the inputs and begin a run (accepted only while idle) |
| tags_in | input | N*TAG_W | Sorted tag vector from the switch |
| recs_in | input | L*N/2 | Record bits from the switch, one per comparator |
| done | output | 1 | One-cycle pulse when the run is complete |
| clean | output | 1 | All record bits zero at the end of the run |
| tags_out | output | N*TAG_W | Restored tag vector |
| recs_out | output | L*N/2 | Record vector after the clean-up |

## Verification
The bench builds the block with LOG_N = 3 and TAG_W = 3. This gives eight tags, six layers and 24 record bits. Every permutation of eight destinations fits in the tag width, so the random cases exercise full one-to-one routing. Random vectors with repeated tags are also reachable, and they bring the equal-tag comparisons behind R8 within reach. Six layers leave room to raise a second start in the middle of a run, and to check that the done pulse lands on the sixth edge after loading.

// File: rtl/swrec_pkg.sv
package swrec_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int layer_total(int log_n);
        return log_n * (log_n + 1) / 2;
    endfunction

    // Stage s (block size 2^s) and step t of a forward layer index.
    function automatic int layer_stage(int log_n, int layer);
        int idx;
        int res;
        idx = 0;
        res = 1;
        for (int s = 1; s <= log_n; s++) begin
            for (int t = 0; t < s; t++) begin
                if (idx == layer) res = s;
                idx++;
            end
        end
        return res;
    endfunction

    function automatic int layer_step(int log_n, int layer);
        int idx;
        int res;
        idx = 0;
        res = 0;
        for (int s = 1; s <= log_n; s++) begin
            for (int t = 0; t < s; t++) begin
                if (idx == layer) res = t;
                idx++;
            end
        end
        return res;
    endfunction

    function automatic int pair_lo(int log_n, int layer, int c);
        int span;
        int half;
        span = 1 << (layer_stage(log_n, layer) - layer_step(log_n, layer));
        half = span / 2;
        return (c / half) * span + (c % half);
    endfunction

    function automatic int pair_hi(int log_n, int layer, int c);
        int span;
        int half;
        span = 1 << (layer_stage(log_n, layer) - layer_step(log_n, layer));
        half = span / 2;
        if (layer_step(log_n, layer) == 0)
            return (c / half) * span + span - 1 - (c % half);
        return (c / half) * span + (c % half) + half;
    endfunction

endpackage

// File: rtl/swrec_undo_elem.sv
module swrec_undo_elem #(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] a_i,
    input  logic [TAG_W-1:0] b_i,
    input  logic             rec_i,
    output logic [TAG_W-1:0] a_o,
    output logic [TAG_W-1:0] b_o,
    output logic             rec_o
);
    logic [TAG_W-1:0] a_s;
    logic [TAG_W-1:0] b_s;

    // R4: un-swap on the stored bit, then re-compare to clear it
    always_comb begin
        a_s   = rec_i ? b_i : a_i;
        b_s   = rec_i ? a_i : b_i;
        rec_o = rec_i & ~(a_s > b_s);
    end

    assign a_o = a_s;
    assign b_o = b_s;
endmodule

// File: rtl/swrec_undo_layer.sv
module swrec_undo_layer #(
    parameter int LOG_N = 3,
    parameter int TAG_W = 4,
    parameter int LAYER = 0
) (
    input  logic [(1<<LOG_N)*TAG_W-1:0] tags_i,
    input  logic [(1<<LOG_N)/2-1:0]     recs_i,
    output logic [(1<<LOG_N)*TAG_W-1:0] tags_o,
    output logic [(1<<LOG_N)/2-1:0]     recs_o
);
    localparam int N    = 1 << LOG_N;
    localparam int HALF = N / 2;

    // Every layer is a perfect matching, so each tag slot is driven once.
    for (genvar c = 0; c < HALF; c++) begin : g_el
        localparam int LO = swrec_pkg::pair_lo(LOG_N, LAYER, c);
        localparam int HI = swrec_pkg::pair_hi(LOG_N, LAYER, c);

        swrec_undo_elem #(.TAG_W(TAG_W)) u_el (
            .a_i   (tags_i[LO*TAG_W +: TAG_W]),
            .b_i   (tags_i[HI*TAG_W +: TAG_W]),
            .rec_i (recs_i[c]),
            .a_o   (tags_o[LO*TAG_W +: TAG_W]),
            .b_o   (tags_o[HI*TAG_W +: TAG_W]),
            .rec_o (recs_o[c])
        );
    end
endmodule

// File: rtl/swrec_cleaner.sv
module swrec_cleaner #(
    parameter int LOG_N = 3,
    parameter int TAG_W = 4
) (
    input  logic                                                      clk,
    input  logic                                                      rst_n,
    input  logic                                                      start,
    input  logic [(1<<LOG_N)*TAG_W-1:0]                               tags_in,
    input  logic [swrec_pkg::layer_total(LOG_N)*((1<<LOG_N)/2)-1:0]   recs_in,
    output logic                                                      done,
    output logic                                                      clean,
    output logic [(1<<LOG_N)*TAG_W-1:0]                               tags_out,
    output logic [swrec_pkg::layer_total(LOG_N)*((1<<LOG_N)/2)-1:0]   recs_out
);
    import swrec_pkg::*;

    localparam int N      = 1 << LOG_N;
    localparam int HALF   = N / 2;
    localparam int LAYERS = layer_total(LOG_N);
    localparam int NREC   = LAYERS * HALF;
    localparam int TV     = N * TAG_W;
    localparam int LW     = (LAYERS > 1) ? $clog2(LAYERS) : 1;

    typedef struct packed {
        phase_e          phase;
        logic [LW-1:0]   layer;
        logic [TV-1:0]   tags;
        logic [NREC-1:0] recs;
        logic            done;
        logic            clean;
    } state_t;

    state_t st_d, st_q;

    logic [TV-1:0]   lay_tags [LAYERS];
    logic [HALF-1:0] lay_recs [LAYERS];
    logic [NREC-1:0] nrec;

    // One combinational inverse layer per forward layer; the counter picks one.
    for (genvar l = 0; l < LAYERS; l++) begin : g_lay
        swrec_undo_layer #(
            .LOG_N (LOG_N),
            .TAG_W (TAG_W),
            .LAYER (l)
        ) u_lay (
            .tags_i (st_q.tags),
            .recs_i (st_q.recs[l*HALF +: HALF]),
            .tags_o (lay_tags[l]),
            .recs_o (lay_recs[l])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        nrec      = st_q.recs;
        nrec[int'(st_q.layer)*HALF +: HALF] = lay_recs[st_q.layer];
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_RUN;
                    st_d.layer = LW'(LAYERS - 1);
                    st_d.tags  = tags_in;
                    st_d.recs  = recs_in;
                    st_d.clean = 1'b0;
                end
            end
            PH_RUN: begin
                st_d.tags = lay_tags[st_q.layer];
                st_d.recs = nrec;
                if (st_q.layer == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.clean = (nrec == '0);
                end else begin
                    st_d.layer = st_q.layer - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.done;
    assign clean    = st_q.clean;
    assign tags_out = st_q.tags;
    assign recs_out = st_q.recs;
endmodule

// File: rtl/swrec_cleaner_chk.sv
module swrec_cleaner_chk #(
    parameter int LOG_N = 3,
    parameter int TAG_W = 4
) (
    input logic                                                    clk,
    input logic                                                    rst_n,
    input logic                                                    start,
    input logic                                                    running,
    input logic                                                    done,
    input logic                                                    clean,
    input logic [(1<<LOG_N)*TAG_W-1:0]                             tags_out,
    input logic [swrec_pkg::layer_total(LOG_N)*((1<<LOG_N)/2)-1:0] recs_out
);
    localparam int LAYERS = swrec_pkg::layer_total(LOG_N);

    int run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                 run_cnt <= 0;
        else if (start && !running) run_cnt <= 0;
        else if (running)           run_cnt <= run_cnt + 1;
    end

    p_done_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == LAYERS));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rec_never_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ((recs_out & ~$past(recs_out)) == '0));

    p_clean_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clean == (recs_out == '0)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> ($stable(tags_out) && $stable(recs_out)));
endmodule

bind swrec_cleaner swrec_cleaner_chk #(
    .LOG_N (LOG_N),
    .TAG_W (TAG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .running  (st_q.phase == swrec_pkg::PH_RUN),
    .done     (done),
    .clean    (clean),
    .tags_out (tags_out),
    .recs_out (recs_out)
);

// File: tb/sim_swrec_cleaner.sv
`timescale 1ns/1ps
module sim_swrec_cleaner;
    localparam int LOG_N = 3;
    localparam int TAG_W = 3;
    localparam int N     = 1 << LOG_N;
    localparam int HALF  = N / 2;
    localparam int L     = LOG_N * (LOG_N + 1) / 2;
    localparam int TV    = N * TAG_W;
    localparam int NR    = L * HALF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TV-1:0] tags_in = '0;
    logic [NR-1:0] recs_in = '0;
    logic          done;
    logic          clean;
    logic [TV-1:0] tags_out;
    logic [NR-1:0] recs_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    swrec_cleaner #(.LOG_N(LOG_N), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .tags_in(tags_in),
        .recs_in(recs_in), .done(done), .clean(clean),
        .tags_out(tags_out), .recs_out(recs_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R5 pairing rule, written from the requirement
    function automatic void bpair(input int l, input int c, output int lo, output int hi);
        int idx;
        int ss;
        int tt;
        int z;
        int h;
        idx = 0; ss = 1; tt = 0;
        for (int s = 1; s <= LOG_N; s++)
            for (int t = 0; t < s; t++) begin
                if (idx == l) begin ss = s; tt = t; end
                idx++;
            end
        z  = 1 << (ss - tt);
        h  = z / 2;
        lo = (c / h) * z + c % h;
        hi = (tt == 0) ? (c / h) * z + z - 1 - c % h : lo + h;
    endfunction

    task automatic fwd(input logic [TV-1:0] t, output logic [TV-1:0] o, output logic [NR-1:0] r);
        int lo, hi;
        logic [TAG_W-1:0] a, b;
        o = t; r = '0;
        for (int l = 0; l < L; l++)
            for (int c = 0; c < HALF; c++) begin
                bpair(l, c, lo, hi);
                a = o[lo*TAG_W +: TAG_W];
                b = o[hi*TAG_W +: TAG_W];
                if (a > b) begin
                    o[lo*TAG_W +: TAG_W] = b;
                    o[hi*TAG_W +: TAG_W] = a;
                    r[l*HALF + c] = 1'b1;
                end
            end
    endtask

    task automatic rev(input logic [TV-1:0] t, input logic [NR-1:0] r,
                       output logic [TV-1:0] o, output logic [NR-1:0] ro);
        int lo, hi;
        logic [TAG_W-1:0] a, b;
        o = t; ro = r;
        for (int l = L - 1; l >= 0; l--)
            for (int c = 0; c < HALF; c++) begin
                bpair(l, c, lo, hi);
                a = o[lo*TAG_W +: TAG_W];
                b = o[hi*TAG_W +: TAG_W];
                if (ro[l*HALF + c]) begin
                    o[lo*TAG_W +: TAG_W] = b;
                    o[hi*TAG_W +: TAG_W] = a;
                    if (b > a) ro[l*HALF + c] = 1'b0;
                end
            end
    endtask

    function automatic logic [TV-1:0] rand_perm();
        int p [N];
        int j, tmp;
        logic [TV-1:0] v;
        for (int i = 0; i < N; i++) p[i] = i;
        for (int i = N - 1; i > 0; i--) begin
            j = int'($urandom_range(i, 0));
            tmp = p[i]; p[i] = p[j]; p[j] = tmp;
        end
        for (int i = 0; i < N; i++) v[i*TAG_W +: TAG_W] = TAG_W'(p[i]);
        return v;
    endfunction

    function automatic logic [TV-1:0] rand_vec();
        logic [TV-1:0] v;
        for (int i = 0; i < N; i++) v[i*TAG_W +: TAG_W] = TAG_W'($urandom);
        return v;
    endfunction

    task automatic run_case(input logic [TV-1:0] ti, input logic [NR-1:0] ri,
                            input logic [TV-1:0] et, input logic [NR-1:0] er,
                            input string req, input bit poke);
        logic [TV-1:0] ht;
        logic [NR-1:0] hr;
        @(negedge clk);
        start = 1'b1; tags_in = ti; recs_in = ri;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R3", "done right after load", 64'(done), 64'd0);
        for (int k = 1; k <= L; k++) begin
            @(negedge clk);
            if (poke && k == 2) begin
                start = 1'b1; tags_in = ~ti; recs_in = ~ri;   // R2 start during run
            end else begin
                start = 1'b0;
            end
            chk(done == (k == L), "R3", "done timing", 64'(done), 64'(k == L));
        end
        chk(tags_out == et, req, "tags", 64'(tags_out), 64'(et));
        chk(recs_out == er, req, "records", 64'(recs_out), 64'(er));
        chk(clean == (er == '0), "R7", "clean flag", 64'(clean), 64'(er == '0));
        ht = tags_out; hr = recs_out;
        @(negedge clk);
        chk(done == 1'b0, "R3", "done single pulse", 64'(done), 64'd0);
        @(negedge clk);
        @(negedge clk);
        chk(tags_out == ht && recs_out == hr, "R9", "idle hold", 64'(tags_out), 64'(ht));
        chk(clean == (er == '0), "R7", "clean held", 64'(clean), 64'(er == '0));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [TV-1:0] orig, srt, et, eq;
        logic [NR-1:0] rr, er, bad;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(done == 0 && clean == 0, "R1", "reset flags", {62'd0, done, clean}, 64'd0);
        chk(tags_out == '0 && recs_out == '0, "R1", "reset vectors", 64'(tags_out), 64'd0);
        rst_n = 1'b1;

        // already sorted: no records
        for (int i = 0; i < N; i++) orig[i*TAG_W +: TAG_W] = TAG_W'(i);
        fwd(orig, srt, rr);
        run_case(srt, rr, orig, '0, "R6", 1'b0);

        // fully reversed input exercises many recorded swaps
        for (int i = 0; i < N; i++) orig[i*TAG_W +: TAG_W] = TAG_W'(N - 1 - i);
        fwd(orig, srt, rr);
        chk(srt == {<<TAG_W{orig}}, "R5", "forward sort of reversed", 64'(srt), 64'({<<TAG_W{orig}}));
        run_case(srt, rr, orig, '0, "R5", 1'b0);

        // random permutations
        for (int n = 0; n < 20; n++) begin
            orig = rand_perm();
            fwd(orig, srt, rr);
            run_case(srt, rr, orig, '0, "R6", 1'b0);
        end

        // random vectors with repeated tags
        for (int n = 0; n < 10; n++) begin
            orig = rand_vec();
            fwd(orig, srt, rr);
            run_case(srt, rr, orig, '0, "R6", 1'b0);
        end

        // start raised mid-run is ignored
        orig = rand_perm();
        fwd(orig, srt, rr);
        run_case(srt, rr, orig, '0, "R2", 1'b1);

        // all-equal tags with one corrupted record bit
        for (int n = 0; n < 4; n++) begin
            eq = '0;
            for (int i = 0; i < N; i++) eq[i*TAG_W +: TAG_W] = TAG_W'(n + 2);
            bad = '0;
            bad[$urandom_range(NR - 1, 0)] = 1'b1;
            run_case(eq, bad, eq, bad, "R8", 1'b0);
        end

        // random corruptions against the inverse-element rule
        for (int n = 0; n < 10; n++) begin
            orig = rand_perm();
            fwd(orig, srt, rr);
            bad = rr;
            bad[$urandom_range(NR - 1, 0)] ^= 1'b1;
            rev(srt, bad, et, er);
            run_case(srt, bad, et, er, "R4", 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule